// File: doc/BRIEF.md
# External frame sync monitor

The block watches an externally supplied frame sync strobe against the reference clock and measures how far the strobe's falling edge lies from the frame boundary that the local frame generator expects. Each time a falling edge is seen, the block publishes the measured distance in reference-clock cycles. It then raises or clears an out-of-limit alarm and decides whether this edge may realign the frame generator.

A two-bit sampling-phase control moves the sampling point in half or whole clock periods, so that a strobe that arrives early or late because of board delays still measures as on target. Permission to realign has two modes. In manual mode a single enable decides. In automatic mode realignment is allowed only when the currently selected reference input is one designated input. An alarm always blocks realignment. The alarm state drives a live output and a sticky flag. The flag is cleared by a one-cycle clear pulse and can raise a maskable interrupt.

The sync strobe idles high. A falling edge that comes before the boundary is measured from the previous boundary, so in practice it reads as a large offset.

Top module: `efs_monitor`

## Requirements
- R1: The sampling phase code selects the tap: 0 = on target, 1 = 0.5 UI early, 2 = 0.5 UI late, 3 = 1 UI late. A strobe displaced by exactly the amount its code names measures the same offset as an on-target strobe. An on-target strobe falls just before the first reference rising edge that follows the cycle in which `frame_mark` is high.
- R2: On each falling edge, `offset` takes the number of whole reference cycles by which the edge follows the expected boundary. An on-target edge reads 0. The count saturates at 2^CW-1, and `offset` holds its value between edges.
- R3: On a falling edge whose offset is greater than `limit`, `alarm` goes to 1.
- R4: On a falling edge whose offset is less than or equal to `limit`, `alarm` goes to 0.
- R5: An edge that sets or keeps the alarm never produces a `resync` pulse.
- R6: With `auto_en` = 0, an in-limit edge produces `resync` exactly when `man_en` = 1.
- R7: With `auto_en` = 1, an in-limit edge produces `resync` exactly when `ref_sel` equals parameter REF_IDX, and `man_en` has no effect.
- R8: `alarm_sticky` goes to 1 when `alarm` goes from 0 to 1, and stays 1 until `sticky_clr` is pulsed. A new alarm in the same cycle as the clear wins.
- R9: `irq` is 1 exactly when `alarm_sticky` and `irq_en` are both 1.
- R10: `resync` is a single-cycle pulse, one per qualifying edge. After reset, `alarm`, `alarm_sticky`, `resync`, `irq` and `offset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External frame sync strobe, idles high |
| frame_mark | input | 1 | One-cycle pulse from the generator marking the expected boundary |
| phase_sel | input | 2 | Sampling phase code (R1) |
| limit | input | 3 | Largest offset still counted as in limit |
| auto_en | input | 1 | Automatic permission mode |
| man_en | input | 1 | Manual realign enable |
| ref_sel | input | SELW | Index of the selected reference input |
| irq_en | input | 1 | Interrupt enable |
| sticky_clr | input | 1 | Clear pulse for the sticky alarm |
| resync | output | 1 | Realign pulse to the frame generator |
| alarm | output | 1 | Live out-of-limit alarm |
| alarm_sticky | output | 1 | Latched alarm |
| irq | output | 1 | Interrupt request |
| offset | output | CW | Last measured offset in reference cycles |

## Verification
The bench builds the block with CW = 8, SELW = 4 and REF_IDX = 11. The 8-bit counter lets a wait of a few hundred cycles reach the saturation value 255. A four-bit selector lets the bench drive both the designated index and a mismatching index. Strobes are placed in whole and half reference periods around the boundary, so each phase code is shown to cancel its own displacement. The limit is exercised exactly at the boundary, one above it and at zero.

// File: rtl/efs_pkg.sv
package efs_pkg;
  typedef enum logic [1:0] {
    PH_ON_TARGET = 2'd0,
    PH_HALF_EARLY = 2'd1,
    PH_HALF_LATE = 2'd2,
    PH_ONE_LATE = 2'd3
  } phase_e;
endpackage

// File: rtl/efs_sampler.sv
module efs_sampler
  import efs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic [1:0] phase_sel,
  output logic       tap
);
  logic p0_q, p1_q, n0_q, n1_q, n2_q;
  phase_e ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= 1'b1;
      p1_q <= 1'b1;
      n1_q <= 1'b1;
      n2_q <= 1'b1;
    end else begin
      p0_q <= sync_in;
      p1_q <= p0_q;
      n1_q <= n0_q;
      n2_q <= n1_q;
    end
  end

  // Opposite-edge sample gives the half-period shifts
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n0_q <= 1'b1;
    else        n0_q <= sync_in;
  end

  // All taps share one nominal latency; each code moves the sample point
  always_comb begin
    ph = phase_e'(phase_sel);
    unique case (ph)
      PH_ON_TARGET:  tap = p1_q;
      PH_HALF_EARLY: tap = n2_q;
      PH_HALF_LATE:  tap = n1_q;
      PH_ONE_LATE:   tap = p0_q;
      default:       tap = p1_q;
    endcase
  end
endmodule

// File: rtl/efs_meter.sv
module efs_meter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tap,
  input  logic          frame_mark,
  output logic          fall,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          tap_q;
  logic          mark_q;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (mark_q)              cnt_n = '0;
    else if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    else                     cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= 1'b1;
      mark_q <= 1'b0;
      cnt_q  <= CNT_MAX;
    end else begin
      tap_q  <= tap;
      mark_q <= frame_mark;
      cnt_q  <= cnt_n;
    end
  end

  assign fall = tap_q & ~tap;
  assign cnt  = cnt_q;

  // R2
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MAX && !$past(mark_q)) |-> cnt_q == CNT_MAX);

  // R10
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/efs_gate.sv
module efs_gate #(
  parameter int CW      = 8,
  parameter int SELW    = 4,
  parameter int REF_IDX = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fall,
  input  logic [CW-1:0]   cnt,
  input  logic [2:0]      limit,
  input  logic            auto_en,
  input  logic            man_en,
  input  logic [SELW-1:0] ref_sel,
  input  logic            sticky_clr,
  input  logic            irq_en,
  output logic [CW-1:0]   offset,
  output logic            alarm,
  output logic            resync,
  output logic            sticky,
  output logic            irq
);
  localparam logic [SELW-1:0] IDX = SELW'(REF_IDX);

  logic [CW-1:0] off_q, off_n;
  logic          alarm_q, alarm_n;
  logic          rs_q, rs_n;
  logic          st_q, st_n;
  logic          over, permit;

  always_comb begin
    over    = cnt > CW'(limit);
    permit  = auto_en ? (ref_sel == IDX) : man_en;
    off_n   = fall ? cnt : off_q;
    alarm_n = fall ? over : alarm_q;
    rs_n    = fall & ~over & permit;
    st_n    = (alarm_n & ~alarm_q) | (st_q & ~sticky_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      alarm_q <= 1'b0;
      rs_q    <= 1'b0;
      st_q    <= 1'b0;
    end else begin
      off_q   <= off_n;
      alarm_q <= alarm_n;
      rs_q    <= rs_n;
      st_q    <= st_n;
    end
  end

  assign offset = off_q;
  assign alarm  = alarm_q;
  assign resync = rs_q;
  assign sticky = st_q;
  assign irq    = st_q & irq_en;

  // R5
  no_resync_in_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |-> !alarm_q);

  // R8
  sticky_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> st_q);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) && !$past(sticky_clr)) |-> st_q);

  // R3
  alarm_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall) |-> $stable(alarm_q));

  // R10
  resync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |=> !rs_q);
endmodule

// File: rtl/efs_monitor.sv
module efs_monitor #(
  parameter int CW      = 8,
  parameter int SELW    = 4,
  parameter int REF_IDX = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_in,
  input  logic            frame_mark,
  input  logic [1:0]      phase_sel,
  input  logic [2:0]      limit,
  input  logic            auto_en,
  input  logic            man_en,
  input  logic [SELW-1:0] ref_sel,
  input  logic            irq_en,
  input  logic            sticky_clr,
  output logic            resync,
  output logic            alarm,
  output logic            alarm_sticky,
  output logic            irq,
  output logic [CW-1:0]   offset
);
  logic          rs_meta, rs_sync;
  logic          tap, fall;
  logic [CW-1:0] cnt;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  efs_sampler u_smp (
    .clk       (clk),
    .rst_n     (rs_sync),
    .sync_in   (sync_in),
    .phase_sel (phase_sel),
    .tap       (tap)
  );

  efs_meter #(.CW(CW)) u_mtr (
    .clk        (clk),
    .rst_n      (rs_sync),
    .tap        (tap),
    .frame_mark (frame_mark),
    .fall       (fall),
    .cnt        (cnt)
  );

  efs_gate #(.CW(CW), .SELW(SELW), .REF_IDX(REF_IDX)) u_gate (
    .clk        (clk),
    .rst_n      (rs_sync),
    .fall       (fall),
    .cnt        (cnt),
    .limit      (limit),
    .auto_en    (auto_en),
    .man_en     (man_en),
    .ref_sel    (ref_sel),
    .sticky_clr (sticky_clr),
    .irq_en     (irq_en),
    .offset     (offset),
    .alarm      (alarm),
    .resync     (resync),
    .sticky     (alarm_sticky),
    .irq        (irq)
  );
endmodule

// File: tb/sim_efs_monitor.sv
`timescale 1ns/1ps
module sim_efs_monitor;
  localparam int CW = 8;
  localparam int SELW = 4;
  localparam int REF_IDX = 11;

  logic clk, rst_n, sync_in, frame_mark, auto_en, man_en, irq_en, sticky_clr;
  logic [1:0] phase_sel;
  logic [2:0] limit;
  logic [SELW-1:0] ref_sel;
  logic resync, alarm, alarm_sticky, irq;
  logic [CW-1:0] offset;

  int checks = 0;
  int fails = 0;
  int rs_cnt = 0;

  efs_monitor #(.CW(CW), .SELW(SELW), .REF_IDX(REF_IDX)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .frame_mark(frame_mark),
    .phase_sel(phase_sel), .limit(limit), .auto_en(auto_en), .man_en(man_en),
    .ref_sel(ref_sel), .irq_en(irq_en), .sticky_clr(sticky_clr),
    .resync(resync), .alarm(alarm), .alarm_sticky(alarm_sticky), .irq(irq),
    .offset(offset)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (resync) rs_cnt++;

  // phase, delay, limit, auto, man, sel, exp offset, exp alarm, exp resync pulses
  typedef struct packed {
    logic [1:0] ph; logic [8:0] d; logic [2:0] lim; logic au; logic mn;
    logic [3:0] sel; logic [7:0] off; logic al; logic rs;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 9'd0, 3'd2, 1'b0, 1'b1, 4'd0,  8'd0, 1'b0, 1'b1},
    '{2'd0, 9'd3, 3'd2, 1'b0, 1'b1, 4'd0,  8'd3, 1'b1, 1'b0},
    '{2'd0, 9'd2, 3'd2, 1'b0, 1'b1, 4'd0,  8'd2, 1'b0, 1'b1},
    '{2'd1, 9'd0, 3'd0, 1'b0, 1'b0, 4'd0,  8'd0, 1'b0, 1'b0},
    '{2'd2, 9'd1, 3'd0, 1'b1, 1'b0, 4'd11, 8'd0, 1'b0, 1'b1},
    '{2'd3, 9'd1, 3'd0, 1'b1, 1'b1, 4'd5,  8'd0, 1'b0, 1'b0},
    '{2'd0, 9'd1, 3'd0, 1'b0, 1'b1, 4'd0,  8'd1, 1'b1, 1'b0},
    '{2'd3, 9'd4, 3'd7, 1'b0, 1'b1, 4'd0,  8'd3, 1'b0, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe falls d ticks after the tick that raises frame_mark
  task automatic strobe(input int ph, input int d, input int lim,
                        input logic au, input logic mn, input int sel);
    phase_sel = 2'(ph); limit = 3'(lim); auto_en = au; man_en = mn;
    ref_sel = SELW'(sel);
    repeat (4) tick();
    frame_mark = 1'b1;
    if (d == 0) sync_in = 1'b0;
    tick();
    frame_mark = 1'b0;
    if (d == 1) sync_in = 1'b0;
    for (int i = 2; i <= d; i++) begin
      tick();
      if (i == d) sync_in = 1'b0;
    end
    repeat (6) tick();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int rs0;
    rst_n = 1'b0; sync_in = 1'b1; frame_mark = 1'b0; phase_sel = 2'd0;
    limit = 3'd0; auto_en = 1'b0; man_en = 1'b0; ref_sel = '0;
    irq_en = 1'b1; sticky_clr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R10 reset state
    chk("R10 alarm", alarm, 0);
    chk("R10 sticky", alarm_sticky, 0);
    chk("R10 resync", resync, 0);
    chk("R10 irq", irq, 0);
    chk("R10 offset", offset, 0);

    // R1 R2 R3 R4 R5 R6 R7 via table
    for (int v = 0; v < NV; v++) begin
      rs0 = rs_cnt;
      strobe(VEC[v].ph, VEC[v].d, VEC[v].lim, VEC[v].au, VEC[v].mn, VEC[v].sel);
      chk("R1/R2 offset", offset, VEC[v].off);
      chk("R3/R4 alarm", alarm, VEC[v].al);
      chk("R5/R6/R7 resync", rs_cnt - rs0, VEC[v].rs);
      sync_in = 1'b1;
      repeat (4) tick();
    end

    // R8 sticky held after alarm cleared by last vector
    chk("R8 sticky held", alarm_sticky, 1);
    chk("R8 live alarm low", alarm, 0);
    // R9 mask
    irq_en = 1'b0; #1;
    chk("R9 irq masked", irq, 0);
    irq_en = 1'b1; #1;
    chk("R9 irq raised", irq, 1);
    // R8 clear pulse
    sticky_clr = 1'b1; tick(); sticky_clr = 1'b0; tick();
    chk("R8 sticky cleared", alarm_sticky, 0);
    chk("R9 irq after clear", irq, 0);

    // R2 saturation at 255
    strobe(0, 300, 7, 1'b0, 1'b1, 0);
    chk("R2 saturated offset", offset, 255);
    chk("R3 alarm at saturation", alarm, 1);
    chk("R8 sticky set again", alarm_sticky, 1);
    sync_in = 1'b1;
    repeat (20) tick();
    chk("R2 offset held", offset, 255);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule